// File: doc/BRIEF.md
# Buffered Crossbar Round-Robin Scheduler

This block schedules cells through a small N x N crossbar in which every crossing of an input row and an output column holds a one-cell buffer. Each input keeps one queue per output on its own side and reports only whether each queue holds a cell, together with that queue's head cell. Every cycle, each input independently picks one queue by round-robin among those whose crossing buffer it believes to be empty, and pops that queue. The popped cell lands in the crossing buffer at the next clock edge.

Each output independently scans the occupied buffers of its own column by round-robin, and on the following edge presents the chosen cell on its link, together with a one-hot tag naming the source input. The delivery empties the crossing buffer and sends a notification back along the row. The input clears its local occupancy flag one edge later, so the two sides share no matching step; they are coupled only through the buffers and the notifications.

Top module: `xbar_rr_sched`

## Requirements
- R1: After a synchronous active-low reset, all crossing buffers are empty, every round-robin pointer points at position 0, no pop is asserted, and out_valid, out_data and out_src are all zero.
- R2: Queue (input i, output j) sits at flat bit i*N+j of voq_occ and voq_pop, and its head cell is at bits (i*N+j)*W upward in voq_data. voq_pop is combinational in the same cycle. Per input it is zero or one-hot, it is never raised during reset, and it is raised only for a queue whose occupancy bit is high and whose local full flag is clear.
- R3: Among its eligible queues, an input picks the first one at or after its pointer, wrapping from N-1 to 0. After a pick, the pointer moves to one past the picked position.
- R4: An input or output with no eligible request asserts nothing, and its pointer keeps its value.
- R5: A popped cell is stored in crossing buffer (i, j) at the next edge. A pop never targets an occupied buffer.
- R6: An output picks the first occupied buffer of its column at or after its pointer, and then moves its pointer one past the pick. The picked cell appears on out_valid/out_data at the next edge, so a cell popped in cycle t leaves no earlier than after the edge ending cycle t+1.
- R7: A delivery empties the buffer at its edge and raises a notification to the owning input. The input clears its flag at the following edge, so a queue that was popped in cycle t can be popped again no earlier than cycle t+3.
- R8: out_src bit j*N+i marks output j delivering from input i. It is one-hot whenever out_valid[j] is high. When out_valid[j] is low, out_src and out_data for output j are zero.
- R9: Outputs decide independently, so several outputs can deliver in the same cycle, each from a different input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| voq_occ | input | N*N | Queue holds at least one cell, bit i*N+j |
| voq_data | input | N*N*W | Head cell of each queue |
| voq_pop | output | N*N | Dequeue strobe for the head cell, bit i*N+j |
| out_valid | output | N | Output link j carries a cell this cycle |
| out_data | output | N*W | Cell on output link j |
| out_src | output | N*N | One-hot source input per output, bit j*N+i |

## Verification
A pop is due in the same cycle in which the bench presents the occupancy. A delivered cell is due one edge after the cycle in which its output picks it, which is at least two edges after the cell's pop, and its queue may pop again three cycles after the earlier pop. The bench drives inputs on the falling edge. One cycle model, written from the requirements, predicts the pop vector in that half cycle and compares it straight away. The same model queues the output vector predicted for the next rising edge, and a monitor compares it two nanoseconds after that edge, so each check reads the registers exactly one edge after the prediction was made.

// File: rtl/xbar_sched_pkg.sv
// Shared helpers for the buffered crossbar scheduler.
// Assumes flat bit layouts: queue/crossing (in i, out j) at i*N+j.
package xbar_sched_pkg;

    // Flat index of the crossing between input row and output column.
    function automatic int xp_index(input int in_p, input int out_p, input int n);
        return in_p * n + out_p;
    endfunction

    // Pointer width for an n-way round-robin arbiter, never below one bit.
    function automatic int ptr_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/xbar_rr_arbiter.sv
// One-hot round-robin arbiter with a pointer that moves one past the winner.
// Assumes N_REQ >= 2. Priority is ranked by distance from the pointer,
// so every select uses a constant index.
module xbar_rr_arbiter #(
    parameter int unsigned N_REQ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req,
    output logic [N_REQ-1:0] grant,
    output logic             granted
);
    localparam int PTR_W = xbar_sched_pkg::ptr_width(int'(N_REQ));
    localparam int NR    = int'(N_REQ);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] win_idx;

    // Find the requester closest to the pointer, going upward with wrap.
    always_comb begin
        int best_rank;
        int rank;
        best_rank = NR;
        win_idx   = '0;
        granted   = 1'b0;
        for (int p = 0; p < NR; p++) begin
            rank = (p >= int'(ptr_q)) ? (p - int'(ptr_q)) : (p + NR - int'(ptr_q));
            if (req[p] && (rank < best_rank)) begin
                best_rank = rank;
                win_idx   = PTR_W'(p);
                granted   = 1'b1;
            end
        end
    end

    // Decode the winner index into a one-hot grant.
    always_comb begin
        for (int p = 0; p < NR; p++) begin
            grant[p] = granted && (win_idx == PTR_W'(p));
        end
    end

    // Move the pointer one past the winner, hold it when nothing wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (granted) begin
            ptr_q <= (win_idx == PTR_W'(N_REQ - 1)) ? '0 : win_idx + 1'b1;
        end
    end

endmodule

// File: rtl/xbar_in_port.sv
// Input-side scheduler for one input row.
// It keeps a local full flag per crossing, sets it on a pop and clears it
// one edge after a delivery notification. It pops one queue per cycle by
// round-robin among queues that hold a cell and whose flag is clear.
module xbar_in_port #(
    parameter int unsigned N_PORTS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PORTS-1:0] voq_occ,
    input  logic [N_PORTS-1:0] notify,
    output logic [N_PORTS-1:0] pop
);
    logic [N_PORTS-1:0] busy_q;
    logic [N_PORTS-1:0] eligible;
    logic               any_pop;

    // A queue may compete only if it has a cell, its crossing is free, and reset is off.
    assign eligible = voq_occ & ~busy_q & {N_PORTS{rst_n}};

    xbar_rr_arbiter #(.N_REQ(N_PORTS)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (eligible),
        .grant   (pop),
        .granted (any_pop)
    );

    // Track which crossing buffers this input believes to be occupied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else begin
            busy_q <= (busy_q & ~notify) | (any_pop ? pop : '0);
        end
    end

endmodule

// File: rtl/xbar_xpoint.sv
// Single-cell crossing buffer with a registered delivery notification.
// Assumes the input never writes while the buffer is occupied, so a write
// and a read never meet in the same cycle.
module xbar_xpoint #(
    parameter int unsigned CELL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CELL_W-1:0] wr_data,
    input  logic              rd_en,
    output logic              full,
    output logic [CELL_W-1:0] data,
    output logic              notify
);
    // Occupancy flag and the notification sent back to the row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full   <= 1'b0;
            notify <= 1'b0;
        end else begin
            full   <= (full & ~rd_en) | wr_en;
            notify <= rd_en;
        end
    end

    // Capture the cell on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (wr_en) begin
            data <= wr_data;
        end
    end

endmodule

// File: rtl/xbar_out_port.sv
// Output-side scheduler for one output column.
// It picks one occupied crossing by round-robin, empties it in the same
// cycle and presents the cell and a one-hot source tag at the next edge.
module xbar_out_port #(
    parameter int unsigned N_PORTS = 4,
    parameter int unsigned CELL_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_PORTS-1:0]        col_full,
    input  logic [N_PORTS*CELL_W-1:0] col_data,
    output logic [N_PORTS-1:0]        take,
    output logic                      valid,
    output logic [CELL_W-1:0]         data,
    output logic [N_PORTS-1:0]        src
);
    logic [N_PORTS-1:0] eligible;
    logic               any_take;
    logic [CELL_W-1:0]  sel_data;

    // Only occupied crossings compete, never during reset.
    assign eligible = col_full & {N_PORTS{rst_n}};

    xbar_rr_arbiter #(.N_REQ(N_PORTS)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (eligible),
        .grant   (take),
        .granted (any_take)
    );

    // AND-OR multiplexer driven by the one-hot grant.
    always_comb begin
        sel_data = '0;
        for (int p = 0; p < int'(N_PORTS); p++) begin
            if (take[p]) begin
                sel_data = sel_data | col_data[p*CELL_W +: CELL_W];
            end
        end
    end

    // Register the output link, which is zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
            src   <= '0;
        end else begin
            valid <= any_take;
            data  <= sel_data;
            src   <= take;
        end
    end

endmodule

// File: rtl/xbar_rr_sched.sv
// Top of the buffered crossbar scheduler: N input schedulers, N*N crossing
// buffers and N output schedulers. The rows and columns share nothing but
// the buffer occupancy and the delivery notifications.
// Assumes N_PORTS >= 2 and that the queues hold voq_data steady until popped.
module xbar_rr_sched #(
    parameter int unsigned N_PORTS = 4,
    parameter int unsigned CELL_W  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_PORTS*N_PORTS-1:0]        voq_occ,
    input  logic [N_PORTS*N_PORTS*CELL_W-1:0] voq_data,
    output logic [N_PORTS*N_PORTS-1:0]        voq_pop,
    output logic [N_PORTS-1:0]                out_valid,
    output logic [N_PORTS*CELL_W-1:0]         out_data,
    output logic [N_PORTS*N_PORTS-1:0]        out_src
);
    localparam int unsigned NN = N_PORTS * N_PORTS;

    logic [NN-1:0]        xp_full;
    logic [NN-1:0]        xp_take;
    logic [NN-1:0]        xp_notify;
    logic [NN*CELL_W-1:0] xp_data;

    logic [N_PORTS-1:0]        col_full [N_PORTS];
    logic [N_PORTS-1:0]        col_take [N_PORTS];
    logic [N_PORTS*CELL_W-1:0] col_data [N_PORTS];

    // One input scheduler per row.
    for (genvar gi = 0; gi < int'(N_PORTS); gi++) begin : g_in
        xbar_in_port #(.N_PORTS(N_PORTS)) u_in (
            .clk     (clk),
            .rst_n   (rst_n),
            .voq_occ (voq_occ[gi*N_PORTS +: N_PORTS]),
            .notify  (xp_notify[gi*N_PORTS +: N_PORTS]),
            .pop     (voq_pop[gi*N_PORTS +: N_PORTS])
        );
    end

    // One buffer per crossing, with the row-to-column wiring.
    for (genvar gi = 0; gi < int'(N_PORTS); gi++) begin : g_row
        for (genvar gj = 0; gj < int'(N_PORTS); gj++) begin : g_col
            localparam int K = xbar_sched_pkg::xp_index(gi, gj, int'(N_PORTS));

            xbar_xpoint #(.CELL_W(CELL_W)) u_xp (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (voq_pop[K]),
                .wr_data (voq_data[K*CELL_W +: CELL_W]),
                .rd_en   (xp_take[K]),
                .full    (xp_full[K]),
                .data    (xp_data[K*CELL_W +: CELL_W]),
                .notify  (xp_notify[K])
            );

            assign col_full[gj][gi]                 = xp_full[K];
            assign col_data[gj][gi*CELL_W +: CELL_W] = xp_data[K*CELL_W +: CELL_W];
            assign xp_take[K]                       = col_take[gj][gi];
        end
    end

    // One output scheduler per column.
    for (genvar gj = 0; gj < int'(N_PORTS); gj++) begin : g_out
        xbar_out_port #(.N_PORTS(N_PORTS), .CELL_W(CELL_W)) u_out (
            .clk      (clk),
            .rst_n    (rst_n),
            .col_full (col_full[gj]),
            .col_data (col_data[gj]),
            .take     (col_take[gj]),
            .valid    (out_valid[gj]),
            .data     (out_data[gj*CELL_W +: CELL_W]),
            .src      (out_src[gj*N_PORTS +: N_PORTS])
        );
    end

endmodule

// File: rtl/xbar_rr_sched_chk.sv
// Property checker for the crossbar scheduler, bound into the top module.
// Assumes reset is held low from time zero until the first edges have passed.
module xbar_rr_sched_chk #(
    parameter int unsigned N_PORTS = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [N_PORTS*N_PORTS-1:0] voq_occ,
    input logic [N_PORTS*N_PORTS-1:0] voq_pop,
    input logic [N_PORTS*N_PORTS-1:0] xp_full,
    input logic [N_PORTS-1:0]         out_valid,
    input logic [N_PORTS*N_PORTS-1:0] out_src
);
    for (genvar gi = 0; gi < int'(N_PORTS); gi++) begin : g_row
        AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(voq_pop[gi*N_PORTS +: N_PORTS])); // R2

        for (genvar gj = 0; gj < int'(N_PORTS); gj++) begin : g_col
            localparam int K = gi * int'(N_PORTS) + gj;
            localparam int S = gj * int'(N_PORTS) + gi;

            AST_POP_NEEDS_CELL: assert property (@(posedge clk) disable iff (!rst_n)
                voq_pop[K] |-> voq_occ[K]); // R2
            AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
                voq_pop[K] |-> !xp_full[K]); // R5
            AST_CELL_STORED: assert property (@(posedge clk) disable iff (!rst_n)
                voq_pop[K] |=> xp_full[K]); // R5
            AST_REFILL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                voq_pop[K] |-> (!$past(voq_pop[K]) && !$past(voq_pop[K], 2))); // R7
            AST_DELIVER_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
                out_src[S] |-> $past(xp_full[K])); // R6
        end
    end

    for (genvar gj = 0; gj < int'(N_PORTS); gj++) begin : g_out
        AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[gj] |-> ($countones(out_src[gj*N_PORTS +: N_PORTS]) == 1)); // R8
        AST_IDLE_NO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid[gj] |-> (out_src[gj*N_PORTS +: N_PORTS] == '0)); // R8
    end

endmodule

bind xbar_rr_sched xbar_rr_sched_chk #(.N_PORTS(N_PORTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .voq_occ   (voq_occ),
    .voq_pop   (voq_pop),
    .xp_full   (xp_full),
    .out_valid (out_valid),
    .out_src   (out_src)
);

// File: tb/xbar_rr_sched_test.sv
// Scoreboard bench. The driver half cycle predicts pops and compares them at
// once, and pushes the predicted output vector. The monitor pops it and
// compares it just after the next rising edge.
module xbar_rr_sched_test;
    localparam int N  = 4;
    localparam int W  = 8;
    localparam int NN = N * N;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NN-1:0]     voq_occ = '0;
    logic [NN*W-1:0]   voq_data = '0;
    logic [NN-1:0]     voq_pop;
    logic [N-1:0]      out_valid;
    logic [N*W-1:0]    out_data;
    logic [NN-1:0]     out_src;

    xbar_rr_sched #(.N_PORTS(N), .CELL_W(W)) uut (
        .clk (clk), .rst_n (rst_n), .voq_occ (voq_occ), .voq_data (voq_data),
        .voq_pop (voq_pop), .out_valid (out_valid), .out_data (out_data), .out_src (out_src)
    );

    always #4 clk = ~clk; // 125 MHz

    typedef struct {
        logic [N-1:0]   valid;
        logic [N*W-1:0] data;
        logic [NN-1:0]  src;
    } exp_t;

    exp_t sb[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;
    bit   rst_req = 1'b1;

    int       cnt [NN];
    int       seq [NN];
    bit       m_busy [NN];
    bit       m_full [NN];
    bit       m_notif[NN];
    logic [W-1:0] m_data [NN];
    int       m_iptr [N];
    int       m_optr [N];

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int rr_pick(input bit [N-1:0] req, input int ptr);
        for (int k = 0; k < N; k++) begin
            if (req[(ptr + k) % N]) return (ptr + k) % N;
        end
        return -1;
    endfunction

    // Driver: queue state onto the pins.
    task automatic drive();
        for (int k = 0; k < NN; k++) begin
            voq_occ[k] = (cnt[k] > 0);
            voq_data[k*W +: W] = W'(k * 16 + (seq[k] % 16));
        end
    endtask

    // Model: predict pops now, then the next state and the next outputs.
    task automatic model_cycle();
        bit [NN-1:0] epop;
        exp_t e;
        int opick [N];
        epop = '0;
        if (rst_n) begin
            for (int i = 0; i < N; i++) begin
                bit [N-1:0] req;
                int p;
                for (int j = 0; j < N; j++) req[j] = (cnt[i*N+j] > 0) && !m_busy[i*N+j];
                p = rr_pick(req, m_iptr[i]);
                if (p >= 0) epop[i*N+p] = 1'b1;
            end
        end
        // R2 R3 R4 R7: pop vector due in this same cycle
        check(voq_pop === epop, "R2 R3 R4 R7 pop vector", 128'(voq_pop), 128'(epop));
        e.valid = '0; e.data = '0; e.src = '0;
        if (!rst_n) begin
            for (int k = 0; k < NN; k++) begin
                m_busy[k] = 0; m_full[k] = 0; m_notif[k] = 0; m_data[k] = '0;
            end
            for (int i = 0; i < N; i++) begin
                m_iptr[i] = 0; m_optr[i] = 0;
            end
        end else begin
            for (int j = 0; j < N; j++) begin
                bit [N-1:0] req;
                for (int i = 0; i < N; i++) req[i] = m_full[i*N+j];
                opick[j] = rr_pick(req, m_optr[j]);
                if (opick[j] >= 0) begin
                    e.valid[j] = 1'b1;
                    e.data[j*W +: W] = m_data[opick[j]*N+j];
                    e.src[j*N+opick[j]] = 1'b1;
                    m_optr[j] = (opick[j] + 1) % N;
                end
            end
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    int k;
                    k = i*N+j;
                    if (m_notif[k]) m_busy[k] = 0;
                    m_notif[k] = (opick[j] == i);
                    if (opick[j] == i) m_full[k] = 0;
                    if (epop[k]) begin
                        m_full[k] = 1; m_busy[k] = 1;
                        m_data[k] = voq_data[k*W +: W];
                        m_iptr[i] = (j + 1) % N;
                        cnt[k]--; seq[k]++;
                    end
                end
            end
        end
        sb.push_back(e);
    endtask

    task automatic run(input int n);
        repeat (n) begin
            @(negedge clk);
            rst_n = rst_req;
            drive();
            #1;
            model_cycle();
        end
    endtask

    task automatic add(input int i, input int j, input int n);
        cnt[i*N+j] += n;
    endtask

    // Monitor: compare registered outputs one edge after their prediction.
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            check(out_valid === e.valid, "R6 R9 out_valid", 128'(out_valid), 128'(e.valid));
            check(out_data === e.data, "R6 R8 out_data", 128'(out_data), 128'(e.data));
            check(out_src === e.src, "R5 R8 out_src", 128'(out_src), 128'(e.src));
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NN; k++) begin
            cnt[k] = 0; seq[k] = 0;
        end
        rst_req = 1'b0;
        add(2, 1, 1); // traffic pending during reset must not pop (R1)
        run(3);
        cnt[2*N+1] = 0;
        rst_req = 1'b1;
        run(2);
        // R1: idle after reset
        check(voq_pop === '0, "R1 no pop after reset", 128'(voq_pop), 128'(0));
        check(out_valid === '0, "R1 out_valid after reset", 128'(out_valid), 128'(0));
        check(out_src === '0, "R1 out_src after reset", 128'(out_src), 128'(0));
        // R6 R7: single cell, then back-to-back cells in one queue
        add(0, 0, 1);
        run(6);
        add(0, 0, 3);
        run(14);
        // R6 R9: all inputs contend for output 2
        for (int i = 0; i < N; i++) add(i, 2, 2);
        run(24);
        // R3: input 1 spreads over every output
        for (int j = 0; j < N; j++) add(1, j, 2);
        run(24);
        // R9: permutation load, every output busy at once
        for (int i = 0; i < N; i++) add(i, (i + 1) % N, 3);
        run(20);
        // Mixed random load
        repeat (200) begin
            if ($urandom_range(0, 2) == 0) cnt[$urandom_range(0, NN - 1)]++;
            run(1);
        end
        run(60);
        for (int k = 0; k < NN; k++) begin
            check(cnt[k] == 0, "R2 queue drained", 128'(cnt[k]), 128'(0));
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule